// File: doc/BRIEF.md
# Frame-Sync Activity Mode Controller

This block decides the operating state of one voice channel by watching which of its timing inputs are moving. It samples the transmit frame sync, the receive frame sync, the pin that carries either the receive master clock or a power-down level, and the pin that carries either the receive bit clock or a clock-frequency select level. From their activity it puts the channel in one of four modes: powered down, full duplex, transmit-only half channel, or receive-only half channel.

Every input is sampled on a fast system clock. An input counts as toggling while an edge has been seen within a window of `ACT_WIN` system clocks. When both frame syncs go quiet, a frame-period timer counts missed frames and powers the channel down after `MISS_FRAMES` of them. A static high on the power-down pin forces power-down at once.

The block also chooses which master clock drives internal sequencing. It reports whether the transmit bit clock must serve both directions, which frequency set is assumed, and which sync's width decides the frame format. After every wake-up it holds the transmit data output off until the second transmit sync pulse.

Top module: `fsync_mode_ctrl`

## Requirements
- R1: During reset `mode_o` is 0 (powered down), `bclk_shared_o` is 1, and `mclk_sel_o`, `freq_sel_o`, `fmt_rx_o`, `tx_en_o`, `rx_en_o` and `tx_out_ok_o` are 0.
- R2: Mode encoding is 0 down, 1 full duplex, 2 transmit half, 3 receive half. With both syncs toggling and no power-down, the mode is 1 and both `tx_en_o` and `rx_en_o` are 1.
- R3: With the transmit sync toggling and the receive sync static, the mode is 2, `tx_en_o` is 1, and `rx_en_o` is 0, so received data is discarded and the receive output parks at mid-scale.
- R4: With the receive sync toggling and the transmit sync static, the mode is 3, and `tx_en_o` and `tx_out_ok_o` are 0, so the transmit data and slot indicator stay in high impedance.
- R5: When both syncs stop, the previous mode holds for `ACT_WIN` + `MISS_FRAMES`·`FRAME_CYC` system clocks (±3) after the last sync edge, and then the mode becomes 0.
- R6: The power-down pin held static high for `ACT_WIN` clocks forces mode 0, even while both syncs keep toggling.
- R7: From mode 0 the channel wakes within a few clocks of a sync becoming active, provided the power-down pin is low or toggling. With no sync activity it stays at 0.
- R8: After each wake-up, `tx_out_ok_o` stays 0 until the second rising transmit sync edge seen while powered. From then on it equals `tx_en_o`.
- R9: `mclk_sel_o` is 1 (receive master clock) only in mode 3 while the receive master clock pin toggles. Otherwise it is 0 (transmit master clock).
- R10: `bclk_shared_o` is 1 while the receive bit clock pin is static. `freq_sel_o` is 1 while that pin toggles, and otherwise equals its static level.
- R11: `fmt_rx_o` (frame format taken from the receive sync width) is 1 exactly in mode 3.
- R12: An input with edges no more than `ACT_WIN`−10 clocks apart counts as toggling at every sample. With gaps of `ACT_WIN`+10 clocks it is reported static for part of each gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all pins |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_sync_i | input | 1 | Transmit frame sync |
| rx_sync_i | input | 1 | Receive frame sync |
| rx_mclk_pd_i | input | 1 | Receive master clock, or static power-down level |
| rx_bclk_sel_i | input | 1 | Receive bit clock, or static frequency-set select |
| mode_o | output | 2 | Channel mode (0 down, 1 full, 2 tx half, 3 rx half) |
| mclk_sel_o | output | 1 | 1 selects the receive master clock for sequencing |
| tx_en_o | output | 1 | Transmit path enabled |
| rx_en_o | output | 1 | Receive path enabled |
| tx_out_ok_o | output | 1 | Transmit data output may leave high impedance |
| bclk_shared_o | output | 1 | Transmit bit clock serves both directions |
| freq_sel_o | output | 1 | Selected master-clock frequency set |
| fmt_rx_o | output | 1 | Frame format decided by the receive sync |

## Verification
The assertions check the following on every cycle:
- The transmit output gate never opens in the cycle that leaves power-down, nor without a powered cycle before it.
- The gate and the transmit enable are both off in receive half-channel mode.
- The receive enable is off in transmit half-channel mode.
- The receive master clock is selected only in receive half-channel mode.

Only the bench scenarios can show the rest:
- Each mode is reached from the right pattern of sync and clock activity.
- The timed power-down delay after the syncs stop.
- The forced power-down from the power-down pin, and the wake-up that follows.
- The two-pulse transmit hold-off counted from the wake-up.
- The activity-window boundary on a slowly toggling pin.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    typedef enum logic [1:0] {
        MODE_DOWN = 2'd0,
        MODE_FULL = 2'd1,
        MODE_TXH  = 2'd2,
        MODE_RXH  = 2'd3
    } chan_mode_e;

endpackage

// File: rtl/fsa_act_det.sv
// Reports whether one sampled pin has shown an edge within the last WIN clocks.
module fsa_act_det #(
    parameter int WIN = 2700
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic active_o,
    output logic level_o
);
    localparam int CW = $clog2(WIN + 1);

    typedef struct packed {
        logic          lvl;
        logic          act;
        logic [CW-1:0] cnt;
    } det_t;

    det_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.lvl = sig_i;
        if (sig_i != s_q.lvl) begin
            s_d.act = 1'b1;
            s_d.cnt = '0;
        end else if (s_q.act) begin
            if (s_q.cnt == CW'(WIN - 1)) begin
                s_d.act = 1'b0;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = s_q.act;
    assign level_o  = s_q.lvl;
endmodule

// File: rtl/fsa_miss_timer.sv
// Counts whole frame periods while both syncs are idle; flags expiry.
module fsa_miss_timer #(
    parameter int FRAME_CYC   = 2560,
    parameter int MISS_FRAMES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_i,
    output logic expire_o
);
    localparam int FW = $clog2(FRAME_CYC);
    localparam int MW = $clog2(MISS_FRAMES + 1);

    typedef struct packed {
        logic [FW-1:0] frm;
        logic [MW-1:0] miss;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!idle_i) begin
            s_d = '0;
        end else if (s_q.frm == FW'(FRAME_CYC - 1)) begin
            s_d.frm = '0;
            if (s_q.miss != MW'(MISS_FRAMES)) s_d.miss = s_q.miss + MW'(1);
        end else begin
            s_d.frm = s_q.frm + FW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign expire_o = (s_q.miss == MW'(MISS_FRAMES));
endmodule

// File: rtl/fsync_mode_ctrl.sv
module fsync_mode_ctrl
    import fsa_pkg::*;
#(
    parameter int ACT_WIN     = 2700,
    parameter int FRAME_CYC   = 2560,
    parameter int MISS_FRAMES = 16,
    parameter int HOLDOFF     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_sync_i,
    input  logic       rx_sync_i,
    input  logic       rx_mclk_pd_i,
    input  logic       rx_bclk_sel_i,
    output logic [1:0] mode_o,
    output logic       mclk_sel_o,
    output logic       tx_en_o,
    output logic       rx_en_o,
    output logic       tx_out_ok_o,
    output logic       bclk_shared_o,
    output logic       freq_sel_o,
    output logic       fmt_rx_o
);
    localparam int NSIG   = 4;
    localparam int IX_TX  = 0;
    localparam int IX_RX  = 1;
    localparam int IX_MCK = 2;
    localparam int IX_BCK = 3;
    localparam int HW     = $clog2(HOLDOFF + 1);

    typedef struct packed {
        chan_mode_e    mode;
        logic [HW-1:0] pulses;
    } ctrl_t;

    logic [NSIG-1:0] sig_raw, sig_act, sig_lvl;
    logic            expired;
    logic            pd_force, any_sync, tx_rise;
    ctrl_t           s_d, s_q;

    assign sig_raw = {rx_bclk_sel_i, rx_mclk_pd_i, rx_sync_i, tx_sync_i};

    for (genvar g = 0; g < NSIG; g++) begin : g_det
        fsa_act_det #(.WIN(ACT_WIN)) u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .sig_i    (sig_raw[g]),
            .active_o (sig_act[g]),
            .level_o  (sig_lvl[g])
        );
    end

    fsa_miss_timer #(.FRAME_CYC(FRAME_CYC), .MISS_FRAMES(MISS_FRAMES)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle_i   (~sig_act[IX_TX] & ~sig_act[IX_RX]),
        .expire_o (expired)
    );

    function automatic chan_mode_e pick_mode(input logic t_on, input logic r_on);
        if (t_on && r_on) return MODE_FULL;
        if (t_on)         return MODE_TXH;
        return MODE_RXH;
    endfunction

    always_comb begin
        s_d      = s_q;
        pd_force = sig_lvl[IX_MCK] & ~sig_act[IX_MCK];
        any_sync = sig_act[IX_TX] | sig_act[IX_RX];
        tx_rise  = tx_sync_i & ~sig_lvl[IX_TX];

        if (pd_force) begin
            s_d.mode = MODE_DOWN;
        end else if (s_q.mode == MODE_DOWN) begin
            if (any_sync) s_d.mode = pick_mode(sig_act[IX_TX], sig_act[IX_RX]);
        end else if (expired) begin
            s_d.mode = MODE_DOWN;
        end else if (any_sync) begin
            s_d.mode = pick_mode(sig_act[IX_TX], sig_act[IX_RX]);
        end

        // wake-up hold-off: count transmit sync pulses seen while powered
        if (s_q.mode == MODE_DOWN || s_d.mode == MODE_DOWN) begin
            s_d.pulses = '0;
        end else if (tx_rise && s_q.pulses != HW'(HOLDOFF)) begin
            s_d.pulses = s_q.pulses + HW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode   <= MODE_DOWN;
            s_q.pulses <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o        = s_q.mode;
    assign tx_en_o       = (s_q.mode == MODE_FULL) || (s_q.mode == MODE_TXH);
    assign rx_en_o       = (s_q.mode == MODE_FULL) || (s_q.mode == MODE_RXH);
    assign tx_out_ok_o   = tx_en_o && (s_q.pulses == HW'(HOLDOFF));
    assign mclk_sel_o    = (s_q.mode == MODE_RXH) && sig_act[IX_MCK];
    assign fmt_rx_o      = (s_q.mode == MODE_RXH);
    assign bclk_shared_o = ~sig_act[IX_BCK];
    assign freq_sel_o    = sig_act[IX_BCK] | sig_lvl[IX_BCK];
endmodule

// File: rtl/fsync_mode_ctrl_chk.sv
module fsync_mode_ctrl_chk
    import fsa_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_o,
    input logic       mclk_sel_o,
    input logic       tx_en_o,
    input logic       rx_en_o,
    input logic       tx_out_ok_o
);
    AST_GATE_AFTER_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_out_ok_o) |-> $past(mode_o) != MODE_DOWN);                        // R8

    AST_WAKE_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == MODE_DOWN && mode_o != MODE_DOWN) |-> !tx_out_ok_o);      // R8

    AST_RXH_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_RXH) |-> (!tx_out_ok_o && !tx_en_o));                      // R4

    AST_TXH_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_TXH) |-> !rx_en_o);                                        // R3

    AST_MCLK_SEL_RXH: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_sel_o |-> (mode_o == MODE_RXH));                                      // R9
endmodule

bind fsync_mode_ctrl fsync_mode_ctrl_chk u_chk (.*);

// File: tb/fsync_mode_ctrl_tb.sv
`timescale 1ns/1ps
module fsync_mode_ctrl_tb;
    localparam int WIN = 40;
    localparam int FRM = 32;
    localparam int MISS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_sync = 1'b0, rx_sync = 1'b0, rx_mclk = 1'b0, rx_bclk = 1'b0;
    logic [1:0] mode;
    logic mclk_sel, tx_en, rx_en, tx_ok, shared, fsel, fmt;

    always #2.5 clk = ~clk;

    fsync_mode_ctrl #(.ACT_WIN(WIN), .FRAME_CYC(FRM), .MISS_FRAMES(MISS)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_sync_i(tx_sync), .rx_sync_i(rx_sync),
        .rx_mclk_pd_i(rx_mclk), .rx_bclk_sel_i(rx_bclk), .mode_o(mode),
        .mclk_sel_o(mclk_sel), .tx_en_o(tx_en), .rx_en_o(rx_en), .tx_out_ok_o(tx_ok),
        .bclk_shared_o(shared), .freq_sel_o(fsel), .fmt_rx_o(fmt));

    // stimulus controls: mck 0 low,1 toggle,2 high; bck 0 low,1 high,2 toggle,3 slow
    logic       tx_on = 1'b0, rx_on = 1'b0;
    logic [1:0] mck = 2'd0, bck = 2'd0;
    int         slow_per = 30;

    initial begin
        int   cyc = 0;
        int   ph = 0;
        logic tx_prev = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (tx_on && !tx_prev) ph = 0; else ph++;
            tx_prev = tx_on;
            tx_sync = tx_on && ((ph % FRM) < 4);
            rx_sync = rx_on && (((cyc + 12) % FRM) < 4);
            rx_mclk = (mck == 2'd1) ? cyc[1] : (mck == 2'd2);
            case (bck)
                2'd0: rx_bclk = 1'b0;
                2'd1: rx_bclk = 1'b1;
                2'd2: rx_bclk = cyc[0];
                default: if (cyc % slow_per == 0) rx_bclk = ~rx_bclk;
            endcase
        end
    end

    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc_wait(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    typedef struct packed {
        logic tx_on; logic rx_on; logic [1:0] mck; logic [1:0] bck;
        logic [1:0] mode; logic sel; logic shr; logic fs; logic fmt;
        logic te; logic re; logic ok;
    } vec_t;

    // output word: {mode, sel, shared, fsel, fmt, tx_en, rx_en, ok}
    localparam vec_t VECS[9] = '{
        '{1'b1,1'b1,2'd0,2'd2, 2'd1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1}, // R2 R10
        '{1'b1,1'b0,2'd1,2'd0, 2'd2,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1}, // R3 R9 R10
        '{1'b0,1'b1,2'd1,2'd1, 2'd3,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0}, // R4 R9 R11
        '{1'b0,1'b1,2'd0,2'd2, 2'd3,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0}, // R9 R11
        '{1'b1,1'b1,2'd2,2'd2, 2'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0}, // R6
        '{1'b1,1'b1,2'd1,2'd2, 2'd1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1}, // R7 R2
        '{1'b0,1'b0,2'd0,2'd0, 2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R5 R10
        '{1'b0,1'b0,2'd0,2'd0, 2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R7
        '{1'b1,1'b0,2'd0,2'd1, 2'd2,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1}  // R3 R7 R10
    };
    string vtag[9] = '{"R2/R10", "R3/R9/R10", "R4/R9/R11", "R9/R11", "R6",
                       "R7/R2", "R5/R10", "R7", "R3/R7/R10"};

    function automatic logic [8:0] outs();
        return {mode, mclk_sel, shared, fsel, fmt, tx_en, rx_en, tx_ok};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic seen;
        cyc_wait(3);
        chk("R1 reset", outs(), 9'b00_0100000);
        rst_n = 1'b1;

        for (int i = 0; i < 9; i++) begin
            tx_on = VECS[i].tx_on; rx_on = VECS[i].rx_on;
            mck = VECS[i].mck;     bck = VECS[i].bck;
            cyc_wait(300);
            chk(vtag[i], outs(), {VECS[i].mode, VECS[i].sel, VECS[i].shr, VECS[i].fs,
                                  VECS[i].fmt, VECS[i].te, VECS[i].re, VECS[i].ok});
        end

        // R5/R7/R8: power down, then wake on the transmit sync and count the hold-off
        tx_on = 1'b0; rx_on = 1'b0; mck = 2'd0; bck = 2'd1;
        cyc_wait(300);
        chk("R5 idle down", {7'd0, mode}, 9'd0);
        tx_on = 1'b1;
        cyc_wait(5);
        chk("R7 wake tx half", {7'd0, mode}, 9'd2);
        cyc_wait(45);
        chk("R8 holdoff first pulse", {8'd0, tx_ok}, 9'd0);
        cyc_wait(30);
        chk("R8 open second pulse", {8'd0, tx_ok}, 9'd1);

        // R5 timed delay from the last sync edge (falling edge of the final pulse)
        @(posedge tx_sync);
        tx_on = 1'b0;
        repeat (2) @(posedge clk);
        cyc_wait(150);
        chk("R5 still up", {6'd0, mode, tx_ok}, {6'd0, 2'd2, 1'b1});
        cyc_wait(40);
        chk("R5 down after delay", {6'd0, mode, tx_ok}, 9'd0);

        // R6 forced down while syncs run; R7/R8 wake with the pin low
        tx_on = 1'b1; rx_on = 1'b1; mck = 2'd1;
        cyc_wait(300);
        chk("R2 full before force", {7'd0, mode}, 9'd1);
        mck = 2'd2;
        cyc_wait(60);
        chk("R6 pin high forces down", {6'd0, mode, tx_en}, 9'd0);
        mck = 2'd0;
        cyc_wait(10);
        chk("R7 wake pin low", {7'd0, mode}, 9'd1);
        chk("R8 gate rearmed", {8'd0, tx_ok}, 9'd0);

        // R12 activity window on a slowly toggling receive bit clock
        slow_per = WIN - 10; bck = 2'd3;
        cyc_wait(WIN);
        seen = 1'b0;
        for (int k = 0; k < 150; k++) begin cyc_wait(1); if (shared) seen = 1'b1; end
        chk("R12 short gaps stay active", {8'd0, seen}, 9'd0);
        slow_per = WIN + 10;
        cyc_wait(WIN + 20);
        seen = 1'b0;
        for (int k = 0; k < 150; k++) begin cyc_wait(1); if (shared) seen = 1'b1; end
        chk("R12 long gaps go static", {8'd0, seen}, 9'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule